// File: doc/BRIEF.md
# Configurable Three-Mode Serial Peripheral Master

This block is a clocked serial master that talks to one peripheral through a serial clock, an active-low select and a data path. A synthesis-time parameter sets the data wiring. In transmit-only mode the block drives a data-out line, which suits converters that only accept data. In receive-only mode it samples a data-in line, which suits converters that only return samples. In half-duplex mode it shares one data pin with the peripheral. The peripheral talks first, and the master then drives the same pin for the rest of the frame while the select is still low.

A host starts a frame with a one-cycle `start` strobe. With that strobe it supplies the outgoing word, the frame length and, in half-duplex mode, the number of bits the peripheral returns before the pin turns around. The block derives its serial clock from the system clock. The divider is chosen so that the serial clock never exceeds a parameterised ceiling. The block frames the transfer with the select line, shifts bits most significant first and controls the output enable of the shared pin. It then hands back the received word together with a one-cycle `done` pulse.

The controller is a seven-state machine. IDLE waits for `start`. LEAD holds the select low for one half period before the first clock edge. HIGH and LOW are the two halves of each serial clock period. TRAIL holds the select low for one half period after the last falling edge. GAP_A and GAP_B keep the select high for two half periods. The transitions are: IDLE→LEAD on an accepted start; LEAD→HIGH and LOW→HIGH on a divider tick (rising edge, sample); HIGH→LOW on a tick when bits remain (falling edge, shift); HIGH→TRAIL on a tick after the last bit; TRAIL→GAP_A on a tick (select released); GAP_A→GAP_B and GAP_B→IDLE on ticks.

Top module: `trimode_spi_master`

## Requirements
- R1: Every half period of the serial clock lasts exactly HALF system clocks, where HALF = ceil(SYS_CLK_HZ / (2·SCLK_MAX_HZ)) and is at least 1. The serial clock therefore never exceeds SCLK_MAX_HZ.
- R2: `sclk` is low whenever `cs_n` is high. `cs_n` falls HALF clocks before the first rising edge and rises HALF clocks after the last falling edge. A frame of L bits keeps `cs_n` low for HALF·(2L+1) clocks and contains exactly L rising edges.
- R3: The 5-bit `frame_len` field gives L, with 0 meaning 32. In transmit-only mode, `mosi` carries `wr_data[L-1:0]` most significant bit first. `mosi` changes only on falling edges and is 0 while `cs_n` is high. `rd_data` stays 0 and `miso` has no effect.
- R4: In receive-only mode the L bits sampled from `miso` on the rising edges are returned right-aligned in `rd_data`, first bit most significant, with the upper bits 0. `mosi` stays 0.
- R5: In half-duplex mode the 5-bit `rd_len` field gives the read count, with 0 meaning 16, limited to L. This count R is the number of bits sampled from `sio_i`. They are returned right-aligned in `rd_data`.
- R6: In half-duplex mode `sio_oe` stays 0 during the first R bits. It goes to 1 on the falling edge that ends bit R (if R < L) and returns to 0 when `cs_n` rises. While it is 1, `sio_o` carries `wr_data[L-R-1:0]` most significant bit first. In the other modes `sio_oe` stays 0.
- R7: `done` is a one-cycle pulse in the cycle after `cs_n` rises. `rd_data` takes its new value in that same cycle and holds it until the next `done`.
- R8: After a frame `cs_n` stays high for at least 2·HALF clocks before the next frame begins. `busy` is 1 from the cycle after an accepted `start` until that gap has ended, and is 1 while `done` is pulsed.
- R9: A `start` that arrives while `busy` is 1 is ignored: it does not change the running frame and does not begin another one.
- R10: After reset `cs_n`=1, `sclk`=0, `mosi`=0, `sio_oe`=0, `busy`=0, `done`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| wr_data | input | MAX_BITS | Outgoing word, right-aligned |
| frame_len | input | LEN_W | Frame length in bits, 0 means MAX_BITS |
| rd_len | input | LEN_W | Bits returned before turnaround (half-duplex), 0 means RD_DEFAULT |
| busy | output | 1 | Frame or trailing gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | MAX_BITS | Received word, right-aligned |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low peripheral select |
| mosi | output | 1 | Serial data out (transmit-only mode) |
| miso | input | 1 | Serial data in (receive-only mode) |
| sio_o | output | 1 | Shared pin output value (half-duplex mode) |
| sio_oe | output | 1 | Shared pin output enable (half-duplex mode) |
| sio_i | input | 1 | Shared pin input value (half-duplex mode) |

## Verification
One instance of each mode runs side by side on the same stimulus. A peripheral model drives a known word, advancing one bit on every falling edge. The frames cover the full 32-bit length and a single-bit length, where the read count is clamped to 1. They also include odd lengths, so that a misplaced alignment shift or an off-by-one frame end shows up. In half-duplex mode the read count is set to equal the length (the master never drives), to be just below it, and to be small. This tells apart a turnaround placed too early (a clash with the peripheral), one placed too late (missing written bits) and one at the wrong bit boundary. Directed cases cover the reset state, a start request issued mid-frame, back-to-back starts that measure the select gap, and the holding of the returned word after `done`.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [1:0] {
        MODE_TX_ONLY     = 2'd0,
        MODE_RX_ONLY     = 2'd1,
        MODE_HALF_DUPLEX = 2'd2
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_TRAIL = 3'd4,
        ST_GAP_A = 3'd5,
        ST_GAP_B = 3'd6
    } fsm_state_e;

    // Smallest half period (in system clocks) that keeps the serial clock
    // at or below the ceiling; never less than one.
    function automatic int unsigned half_period_cycles(
        input int unsigned sys_hz,
        input int unsigned max_hz
    );
        int unsigned full_div;
        full_div = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        return (full_div < 1) ? 1 : full_div;
    endfunction

endpackage

// File: rtl/tsm_clk_div.sv
module tsm_clk_div #(
    parameter int unsigned HALF = 3,
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));
    assign tick = run && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    generate
        if (HALF > 1) begin : g_gap_check
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R1
        end
    endgenerate

endmodule

// File: rtl/tsm_ctrl_fsm.sv
module tsm_ctrl_fsm
    import tsm_pkg::*;
#(
    parameter xfer_mode_e  XFER_MODE = MODE_HALF_DUPLEX,
    parameter int unsigned CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] len_in,
    input  logic [CNT_W-1:0] rd_in,
    output logic             run,
    output logic             busy,
    output logic             sclk,
    output logic             cs_n,
    output logic             oe,
    output logic             done,
    output logic             load_ev,
    output logic             shift_ev,
    output logic             cap_ev,
    output logic             publish
);

    fsm_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] rd_q;
    logic             sclk_q, cs_n_q, oe_q, pub_q, done_q;

    logic rise_ev, fall_ev, end_ev, last_bit, in_read;

    assign load_ev  = start && (state_q == ST_IDLE);
    assign rise_ev  = tick && ((state_q == ST_LEAD) || (state_q == ST_LOW));
    assign fall_ev  = tick && (state_q == ST_HIGH);
    assign end_ev   = tick && (state_q == ST_TRAIL);
    assign last_bit = (bit_cnt_q == len_q - CNT_W'(1));
    assign in_read  = (XFER_MODE == MODE_HALF_DUPLEX) ? (bit_cnt_q < rd_q) : 1'b1;

    assign shift_ev = fall_ev;
    assign cap_ev   = rise_ev && (XFER_MODE != MODE_TX_ONLY) && in_read;
    assign publish  = pub_q;
    assign run      = (state_q != ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign sclk     = sclk_q;
    assign cs_n     = cs_n_q;
    assign oe       = oe_q;
    assign done     = done_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_HIGH;
            ST_HIGH:  if (tick)  state_d = last_bit ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick)  state_d = ST_HIGH;
            ST_TRAIL: if (tick)  state_d = ST_GAP_A;
            ST_GAP_A: if (tick)  state_d = ST_GAP_B;
            ST_GAP_B: if (tick)  state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            cs_n_q    <= 1'b1;
            oe_q      <= 1'b0;
            pub_q     <= 1'b0;
            done_q    <= 1'b0;
            bit_cnt_q <= '0;
            len_q     <= '0;
            rd_q      <= '0;
        end else begin
            pub_q  <= end_ev;
            done_q <= pub_q;
            if (load_ev) begin
                cs_n_q    <= 1'b0;
                sclk_q    <= 1'b0;
                oe_q      <= 1'b0;
                bit_cnt_q <= '0;
                len_q     <= len_in;
                rd_q      <= rd_in;
            end
            if (rise_ev) begin
                sclk_q <= 1'b1;
            end
            if (fall_ev) begin
                sclk_q    <= 1'b0;
                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                if ((XFER_MODE == MODE_HALF_DUPLEX) && !last_bit &&
                    ((bit_cnt_q + CNT_W'(1)) == rd_q)) begin
                    oe_q <= 1'b1;
                end
            end
            if (end_ev) begin
                cs_n_q <= 1'b1;
                oe_q   <= 1'b0;
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q); // R2
    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_q) |-> $past(tick)); // R1
    AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (!cs_n_q && (bit_cnt_q >= rd_q))); // R6
    AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cs_n_q && !$past(cs_n_q, 2))); // R7
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> busy); // R8
    AST_CS_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |=> cs_n_q); // R8

endmodule

// File: rtl/tsm_shifter.sv
module tsm_shifter #(
    parameter int unsigned MAX_BITS = 32,
    parameter int unsigned CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_ev,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic [CNT_W-1:0]    len_in,
    input  logic                shift_ev,
    input  logic                cap_ev,
    input  logic                in_bit,
    input  logic                publish,
    output logic                tx_bit,
    output logic [MAX_BITS-1:0] rd_data
);

    logic [MAX_BITS-1:0] tx_sr_q;
    logic [MAX_BITS-1:0] rx_sr_q;
    logic [MAX_BITS-1:0] rd_q;
    logic [CNT_W-1:0]    align;

    // Left-align the outgoing word so that its top bit sits at the MSB.
    assign align   = CNT_W'(MAX_BITS) - len_in;
    assign tx_bit  = tx_sr_q[MAX_BITS-1];
    assign rd_data = rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr_q <= '0;
            rx_sr_q <= '0;
            rd_q    <= '0;
        end else begin
            if (load_ev) begin
                tx_sr_q <= wr_data << align;
                rx_sr_q <= '0;
            end else begin
                if (shift_ev) begin
                    tx_sr_q <= {tx_sr_q[MAX_BITS-2:0], 1'b0};
                end
                if (cap_ev) begin
                    rx_sr_q <= {rx_sr_q[MAX_BITS-2:0], in_bit};
                end
            end
            if (publish) begin
                rd_q <= rx_sr_q;
            end
        end
    end

endmodule

// File: rtl/trimode_spi_master.sv
module trimode_spi_master
    import tsm_pkg::*;
#(
    parameter xfer_mode_e  XFER_MODE   = MODE_HALF_DUPLEX,
    parameter int unsigned SYS_CLK_HZ  = 125_000_000,
    parameter int unsigned SCLK_MAX_HZ = 25_000_000,
    parameter int unsigned MAX_BITS    = 32,
    parameter int unsigned RD_DEFAULT  = 16,
    localparam int unsigned LEN_W      = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [LEN_W-1:0]    rd_len,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rd_data,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso,
    output logic                sio_o,
    output logic                sio_oe,
    input  logic                sio_i
);

    localparam int unsigned CNT_W = LEN_W + 1;
    localparam int unsigned HALF  = half_period_cycles(SYS_CLK_HZ, SCLK_MAX_HZ);

    logic [CNT_W-1:0] len_eff, rd_req, rd_eff;
    logic run, tick, load_ev, shift_ev, cap_ev, publish, tx_bit, in_bit;
    logic cs_n_w, oe_w;

    // Field decode: zero selects the full width / the default read count.
    always_comb begin
        len_eff = (frame_len == '0) ? CNT_W'(MAX_BITS) : {1'b0, frame_len};
        rd_req  = (rd_len == '0) ? CNT_W'(RD_DEFAULT) : {1'b0, rd_len};
        rd_eff  = (rd_req > len_eff) ? len_eff : rd_req;
    end

    tsm_clk_div #(
        .HALF (HALF)
    ) clk_div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    tsm_ctrl_fsm #(
        .XFER_MODE (XFER_MODE),
        .CNT_W     (CNT_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .len_in   (len_eff),
        .rd_in    (rd_eff),
        .run      (run),
        .busy     (busy),
        .sclk     (sclk),
        .cs_n     (cs_n_w),
        .oe       (oe_w),
        .done     (done),
        .load_ev  (load_ev),
        .shift_ev (shift_ev),
        .cap_ev   (cap_ev),
        .publish  (publish)
    );

    tsm_shifter #(
        .MAX_BITS (MAX_BITS),
        .CNT_W    (CNT_W)
    ) shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_ev  (load_ev),
        .wr_data  (wr_data),
        .len_in   (len_eff),
        .shift_ev (shift_ev),
        .cap_ev   (cap_ev),
        .in_bit   (in_bit),
        .publish  (publish),
        .tx_bit   (tx_bit),
        .rd_data  (rd_data)
    );

    assign cs_n   = cs_n_w;
    assign sio_oe = oe_w;

    generate
        if (XFER_MODE == MODE_TX_ONLY) begin : g_tx_only
            wire unused_pins = miso ^ sio_i;
            assign mosi   = tx_bit & ~cs_n_w;
            assign sio_o  = 1'b0;
            assign in_bit = 1'b0;
        end else if (XFER_MODE == MODE_RX_ONLY) begin : g_rx_only
            wire unused_pins = sio_i ^ tx_bit;
            assign mosi   = 1'b0;
            assign sio_o  = 1'b0;
            assign in_bit = miso;
        end else begin : g_half_duplex
            wire unused_pins = miso;
            assign mosi   = 1'b0;
            assign sio_o  = tx_bit & oe_w;
            assign in_bit = sio_i;
        end
    endgenerate

endmodule

// File: tb/trimode_spi_master_tb_top.sv
`timescale 1ns/1ps
module trimode_spi_master_tb_top;
    import tsm_pkg::*;

    localparam int HALF_T = 3; // ceil(125 MHz / (2 * 25 MHz))

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic        start = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  frame_len = '0;
    logic [4:0]  rd_len = '0;
    logic        miso_r = 1'b0;
    logic        sio_i_h = 1'b0;

    logic busy_t, done_t, sclk_t, cs_t, mosi_t, sio_o_t, oe_t;
    logic busy_r, done_r, sclk_r, cs_r, mosi_r, sio_o_r, oe_r;
    logic busy_h, done_h, sclk_h, cs_h, mosi_h, sio_o_h, oe_h;
    logic [31:0] rd_t, rd_r, rd_h;

    trimode_spi_master #(.XFER_MODE(MODE_HALF_DUPLEX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data),
        .frame_len(frame_len), .rd_len(rd_len), .busy(busy_h), .done(done_h),
        .rd_data(rd_h), .sclk(sclk_h), .cs_n(cs_h), .mosi(mosi_h),
        .miso(1'b1), .sio_o(sio_o_h), .sio_oe(oe_h), .sio_i(sio_i_h));

    trimode_spi_master #(.XFER_MODE(MODE_TX_ONLY)) dut_tx_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data),
        .frame_len(frame_len), .rd_len(rd_len), .busy(busy_t), .done(done_t),
        .rd_data(rd_t), .sclk(sclk_t), .cs_n(cs_t), .mosi(mosi_t),
        .miso(1'b1), .sio_o(sio_o_t), .sio_oe(oe_t), .sio_i(1'b1));

    trimode_spi_master #(.XFER_MODE(MODE_RX_ONLY)) dut_rx_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data),
        .frame_len(frame_len), .rd_len(rd_len), .busy(busy_r), .done(done_r),
        .rd_data(rd_r), .sclk(sclk_r), .cs_n(cs_r), .mosi(mosi_r),
        .miso(miso_r), .sio_o(sio_o_r), .sio_oe(oe_r), .sio_i(1'b1));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Current frame as seen by the peripheral model
    int          cur_len = 1;
    int          cur_rd  = 1;
    logic [31:0] cur_tgt = '0;

    // Monitor state
    int cyc = 0, kf = 0;
    logic prv_sclk_t = 0, prv_sclk_h = 0, prv_cs_h = 1;
    logic [31:0] tx_cap, hd_cap;
    int tx_rises, hd_n, rx_mosi_seen, clash, hi_run, hi_min, hi_max;
    int cs_low_run, cs_low_len, gap_run, gap_min, cs_rise_cyc, frames;
    bit seen_frame = 0;

    function automatic logic tgt_bit(input int k);
        if (k < cur_len) return cur_tgt[cur_len-1-k];
        return 1'b0;
    endfunction

    task automatic clear_mon();
        tx_cap = '0; hd_cap = '0; tx_rises = 0; hd_n = 0; rx_mosi_seen = 0;
        clash = 0; hi_run = 0; hi_min = 1000; hi_max = 0; cs_low_len = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_h) kf = 0;
            else if (prv_sclk_h && !sclk_h) kf++;
            if (!prv_sclk_t && sclk_t) begin
                tx_cap = {tx_cap[30:0], mosi_t};
                tx_rises++;
            end
            if (!prv_sclk_h && sclk_h && oe_h) begin
                hd_cap = {hd_cap[30:0], sio_o_h};
                hd_n++;
            end
            if (mosi_r || (cs_t && mosi_t)) rx_mosi_seen++;
            if (oe_h && !cs_h && kf < cur_rd) clash++;
            if (oe_t || oe_r || (cs_h && oe_h)) clash++;
            if (sclk_h) hi_run++;
            if (!sclk_h && prv_sclk_h) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                hi_run = 0;
            end
            if (!cs_h) cs_low_run++;
            if (cs_h && !prv_cs_h) begin
                cs_low_len = cs_low_run; cs_low_run = 0;
                cs_rise_cyc = cyc; seen_frame = 1; gap_run = 0;
            end
            if (cs_h) gap_run++;
            if (!cs_h && prv_cs_h) begin
                frames++;
                if (seen_frame && gap_run < gap_min) gap_min = gap_run;
            end
            miso_r  = tgt_bit(kf);
            sio_i_h = oe_h ? sio_o_h : ((kf < cur_rd) ? tgt_bit(kf) : 1'b0);
            prv_sclk_t = sclk_t; prv_sclk_h = sclk_h; prv_cs_h = cs_h;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pulse_start(input logic [4:0] fl, input logic [4:0] rl, input logic [31:0] wr);
        frame_len = fl; rd_len = rl; wr_data = wr;
        start = 1'b1; step(); start = 1'b0;
    endtask

    task automatic set_target(input logic [4:0] fl, input logic [4:0] rl, input logic [31:0] tg);
        int rs;
        cur_len = (fl == 0) ? 32 : int'(fl);
        rs = (rl == 0) ? 16 : int'(rl);
        cur_rd = (rs > cur_len) ? cur_len : rs;
        cur_tgt = tg;
    endtask

    int done_cyc;
    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done_h && n < 3000) begin step(); n++; end
        done_cyc = cyc;
        chk({tag, " done seen"}, 32'(done_h), 32'd1);
    endtask

    function automatic logic [31:0] lmask(input int n);
        if (n >= 32) return '1;
        return (32'h1 << n) - 32'h1;
    endfunction

    // {frame_len[4:0], rd_len[4:0], wr_data[31:0], target[31:0]}
    localparam logic [73:0] VEC [6] = '{
        {5'd0,  5'd0,  32'hC3A5_0F96, 32'h8E1D_47B2},
        {5'd8,  5'd3,  32'h0000_005A, 32'h0000_00C9},
        {5'd1,  5'd0,  32'h0000_0001, 32'h0000_0001},
        {5'd20, 5'd16, 32'h000B_3C6E, 32'h0004_D1F7},
        {5'd16, 5'd0,  32'h0000_FFFF, 32'h0000_2468},
        {5'd31, 5'd30, 32'h5555_AAAA, 32'h7F00_FF01}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        clear_mon();
        gap_min = 100000; frames = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk("R10 cs_n", 32'(cs_h), 32'd1);
        chk("R10 sclk", 32'(sclk_h), 32'd0);
        chk("R10 mosi", 32'(mosi_t), 32'd0);
        chk("R10 sio_oe", 32'(oe_h), 32'd0);
        chk("R10 busy", 32'({busy_h, busy_t, busy_r}), 32'd0);
        chk("R10 done", 32'({done_h, done_t, done_r}), 32'd0);
        chk("R10 rd_data", rd_h | rd_t | rd_r, 32'd0);

        for (int i = 0; i < 6; i++) begin
            logic [4:0] fl, rl;
            logic [31:0] wr, tg, m, exp_hd;
            int wn;
            fl = VEC[i][73:69]; rl = VEC[i][68:64];
            wr = VEC[i][63:32]; tg = VEC[i][31:0];
            clear_mon();
            set_target(fl, rl, tg);
            m = lmask(cur_len);
            pulse_start(fl, rl, wr);
            wait_done("R7");
            chk("R7 done one cycle after cs_n rise", 32'(done_cyc - cs_rise_cyc), 32'd1);
            chk("R7 done on all modes", 32'({done_t, done_r}), 32'h3);
            chk("R8 busy during done", 32'(busy_h), 32'd1);
            chk("R2 cs_n low length", 32'(cs_low_len), 32'(HALF_T * (2 * cur_len + 1)));
            chk("R2 rising edge count", 32'(tx_rises), 32'(cur_len));
            chk("R1 high phase min", 32'(hi_min), 32'(HALF_T));
            chk("R1 high phase max", 32'(hi_max), 32'(HALF_T));
            chk("R3 mosi bits", tx_cap & m, wr & m);
            chk("R3 tx-only rd_data", rd_t, 32'd0);
            chk("R4 rx-only rd_data", rd_r, tg & m);
            chk("R4 mosi quiet", 32'(rx_mosi_seen), 32'd0);
            exp_hd = (tg & m) >> (cur_len - cur_rd);
            chk("R5 half-duplex rd_data", rd_h, exp_hd);
            wn = cur_len - cur_rd;
            chk("R6 driven bit count", 32'(hd_n), 32'(wn));
            chk("R6 driven bits", hd_cap & lmask(wn), wr & lmask(wn));
            chk("R6 no pin clash", 32'(clash), 32'd0);
            repeat (12) step();
        end

        // R7: returned word holds after done
        held = rd_h;
        repeat (10) step();
        chk("R7 rd_data held", rd_h, held);

        // R9: start while busy is ignored
        clear_mon();
        set_target(5'd8, 5'd8, 32'h0000_0033);
        frames = 0;
        pulse_start(5'd8, 5'd8, 32'h0000_00A5);
        repeat (20) step();
        pulse_start(5'd0, 5'd1, 32'hFFFF_FFFF);
        wait_done("R9");
        chk("R9 frame kept its length", 32'(cs_low_len), 32'(HALF_T * 17));
        chk("R9 frame kept its data", tx_cap, 32'h0000_00A5);
        repeat (60) step();
        chk("R9 no extra frame", 32'(frames), 32'd1);
        chk("R9 select idle", 32'(cs_h), 32'd1);

        // R8: back-to-back requests keep the gap
        clear_mon();
        set_target(5'd4, 5'd4, 32'h0000_0009);
        gap_min = 100000; seen_frame = 0; frames = 0;
        frame_len = 5'd4; rd_len = 5'd4; wr_data = 32'h6;
        start = 1'b1;
        wait_done("R8 first");
        step();
        wait_done("R8 second");
        start = 1'b0;
        chk("R8 two frames", 32'(frames), 32'd2);
        chk("R8 gap at least two half periods", 32'(gap_min >= 2 * HALF_T), 32'd1);
        repeat (20) step();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule